// File: doc/BRIEF.md
# FIFO Command Status Sequencer

This block is the status-register state machine behind a byte-wide command/response port of a security coprocessor. The host pushes command bytes one at a time and steers the block through four phases, ready, command reception, execution and response, by writing control bits into a status register and a cancel bit into an extended status register. The block reports its phase through a status byte, a 16-bit burst count and an extended status byte. Execution itself is handed to an engine over a one-cycle start pulse and a done strobe that carries a 32-bit return code.

The command is sized by a big-endian 32-bit length in command bytes 2 to 5, and the block keeps asking for bytes until that many have arrived, capped by the depth of its byte counter. Every response is a fixed 10-byte frame: tag `80 01`, size `00 00 00 0A`, then the return code, most significant byte first. The frame is produced from the stored return code, so no response memory is needed. A cancel during execution ends the command at once with the cancelled code `0x00000909`; retry replays the frame from its start.

Top module: `cmdseq_top`

## Requirements
- R1: After reset the status byte is 0xCC (bit 7 valid, bit 6 ready, bit 3 expect, bit 2 self-test done), the extended status byte is 0x04 (bits 3:2 = 01, second-generation family), burst count is 6 and readData is 0.
- R2: A data write (hostWrSel = 2) in the ready phase starts command reception: ready (bit 6) drops to 0 and expect (bit 3) stays 1.
- R3: Expect stays 1 until the byte count reaches the larger of 6 and the length in bytes 2 to 5 (big-endian), capped at MAX_CMD; data writes while expect is 0 are ignored.
- R4: Burst count equals min(BURST_MAX, bytes still expected) in ready and reception, min(BURST_MAX, response bytes left) in the response phase, and 0 during execution.
- R5: Writing status bit 5 (go) is accepted only in reception with expect 0; it moves to execution (status 0x84) and pulses engStart for one cycle, one cycle after the write. Elsewhere it is ignored.
- R6: engDone during execution enters the response phase: data-available (bit 4) is 1, ready is 0.
- R7: Each hostRdEn pop advances through the 10-byte frame 80 01 00 00 00 0A rc[31:24] rc[23:16] rc[15:8] rc[7:0]; after the last byte data-available is 0, readData is 0 and further pops have no effect.
- R8: Writing status bit 1 (retry) in the response phase rewinds the frame to byte 0; in any other phase it is ignored.
- R9: Writing extended status bit 0 (cancel, hostWrSel = 1) during execution enters the response phase with return code 0x00000909 and pulses engCancel one cycle after the write; a later engDone is ignored.
- R10: A cancel write outside execution is ignored; in the response phase the read position and the return code are unchanged.
- R11: Writing status bit 6 (command-ready) in reception or response returns to the ready phase and discards the command or remaining response; in execution it is ignored.
- R12: Within one status write, command-ready takes priority over go and over retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write strobe |
| hostWrSel | input | 2 | Write target: 0 status, 1 extended status, 2 data |
| hostWrData | input | 8 | Host write byte |
| hostRdEn | input | 1 | Pop one response byte |
| readData | output | 8 | Current response byte, 0 when none is available |
| statusByte | output | 8 | Status byte |
| extStatusByte | output | 8 | Extended status byte |
| burstCount | output | 16 | Bytes the host may move back to back |
| engStart | output | 1 | One-cycle start pulse to the engine |
| engCancel | output | 1 | One-cycle abort pulse to the engine |
| engDone | input | 1 | Engine completion strobe |
| engRc | input | 32 | Engine return code, sampled with engDone |

## Verification
Every host write, pop or engine strobe is registered on the next rising edge, so status, burst count and readData reflect it one cycle later, and engStart and engCancel pulse in that same cycle and are gone the cycle after. The bench drives each stimulus for exactly one cycle from a falling edge and compares outputs at the following falling edge, half a cycle after the registering edge. readData is combinational from the read position, so each frame byte is compared before the pop that moves past it.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  typedef enum logic [1:0] {
    PH_READY = 2'd0,
    PH_RECV  = 2'd1,
    PH_EXEC  = 2'd2,
    PH_RESP  = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic rdRewind;
    logic rdInc;
    logic rcLoadEng;
    logic rcLoadCancel;
  } strobe_t;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_EXT    = 2'd1;
  localparam logic [1:0] SEL_FIFO   = 2'd2;

  localparam int BIT_VALID  = 7;
  localparam int BIT_READY  = 6;
  localparam int BIT_GO     = 5;
  localparam int BIT_AVAIL  = 4;
  localparam int BIT_EXPECT = 3;
  localparam int BIT_SELF   = 2;
  localparam int BIT_RETRY  = 1;
  localparam int BIT_CANCEL = 0;

  localparam int HDR_LEN  = 6;
  localparam int RESP_LEN = 10;

endpackage

// File: rtl/cmdseq_data.sv
module cmdseq_data
  import cmdseq_pkg::*;
#(
  parameter int MAX_CMD   = 16,
  parameter int BURST_MAX = 8,
  parameter logic [31:0] CANCEL_RC = 32'h0000_0909
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [7:0]  wrByte,
  input  phase_t      phase,
  input  logic [31:0] engRc,
  output logic        needMore,
  output logic        respLeft,
  output logic [15:0] burstCount,
  output logic [7:0]  readData
);
  localparam int CW = $clog2(MAX_CMD + 1);

  logic [CW-1:0] cnt;
  logic [31:0]   lenReg;
  logic [3:0]    rdIdx;
  logic [31:0]   rcReg;

  logic [31:0] cntW, limW, effW, cmdRem, respRem, burstW;
  logic [7:0]  frameByte;

  always_comb begin
    cntW = 32'(cnt);
    limW = (lenReg > 32'(MAX_CMD)) ? 32'(MAX_CMD) : lenReg;
    effW = (limW < 32'(HDR_LEN)) ? 32'(HDR_LEN) : limW;
    needMore = (cntW < effW);
    if (cntW < 32'(HDR_LEN)) cmdRem = 32'(HDR_LEN) - cntW;
    else if (needMore)       cmdRem = effW - cntW;
    else                     cmdRem = 32'd0;
    respLeft = (rdIdx < 4'(RESP_LEN));
    respRem  = 32'(RESP_LEN) - 32'(rdIdx);
    case (phase)
      PH_READY, PH_RECV: burstW = (cmdRem > 32'(BURST_MAX)) ? 32'(BURST_MAX) : cmdRem;
      PH_RESP:           burstW = (respRem > 32'(BURST_MAX)) ? 32'(BURST_MAX) : respRem;
      default:           burstW = 32'd0;
    endcase
    burstCount = burstW[15:0];
  end

  // fixed response frame built from the stored return code
  always_comb begin
    case (rdIdx)
      4'd0:    frameByte = 8'h80;
      4'd1:    frameByte = 8'h01;
      4'd5:    frameByte = 8'(RESP_LEN);
      4'd6:    frameByte = rcReg[31:24];
      4'd7:    frameByte = rcReg[23:16];
      4'd8:    frameByte = rcReg[15:8];
      4'd9:    frameByte = rcReg[7:0];
      default: frameByte = 8'h00;
    endcase
    readData = (phase == PH_RESP && respLeft) ? frameByte : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      lenReg <= '0;
    end else if (stb.cntClear) begin
      cnt    <= '0;
      lenReg <= '0;
    end else if (stb.cntInc) begin
      cnt <= cnt + 1'b1;
      if (cntW >= 32'd2 && cntW <= 32'd5) lenReg <= {lenReg[23:0], wrByte};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx <= '0;
      rcReg <= '0;
    end else begin
      if (stb.rdRewind)   rdIdx <= '0;
      else if (stb.rdInc) rdIdx <= rdIdx + 1'b1;
      if (stb.rcLoadCancel)   rcReg <= CANCEL_RC;
      else if (stb.rcLoadEng) rcReg <= engRc;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    32'(cnt) <= 32'(MAX_CMD)); // R3
  AST_RD_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    rdIdx <= 4'(RESP_LEN)); // R7
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rstN)
    32'(burstCount) <= 32'(BURST_MAX)); // R4
  AST_EXEC_NO_BURST: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_EXEC |-> burstCount == 16'd0); // R4

endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
  import cmdseq_pkg::*;
#(
  parameter bit SELF_TEST_DONE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic [1:0] hostWrSel,
  input  logic [7:0] hostWrData,
  input  logic       hostRdEn,
  input  logic       engDone,
  input  logic       needMore,
  input  logic       respLeft,
  output phase_t     phase,
  output strobe_t    stb,
  output logic [7:0] statusByte,
  output logic       engStart,
  output logic       engCancel
);
  phase_t phaseNext;
  logic   startNext, cancelNext;
  logic   wrStatus, wrExt, wrFifo;
  logic   cmdReadyW, goW, retryW, cancelW;

  assign wrStatus  = hostWrEn && hostWrSel == SEL_STATUS;
  assign wrExt     = hostWrEn && hostWrSel == SEL_EXT;
  assign wrFifo    = hostWrEn && hostWrSel == SEL_FIFO;
  assign cmdReadyW = wrStatus && hostWrData[BIT_READY];
  assign goW       = wrStatus && hostWrData[BIT_GO];
  assign retryW    = wrStatus && hostWrData[BIT_RETRY];
  assign cancelW   = wrExt && hostWrData[BIT_CANCEL];

  always_comb begin
    phaseNext  = phase;
    stb        = '0;
    startNext  = 1'b0;
    cancelNext = 1'b0;
    case (phase)
      PH_READY: begin
        if (wrFifo) begin
          stb.cntInc = 1'b1;
          phaseNext  = PH_RECV;
        end
      end
      PH_RECV: begin
        if (cmdReadyW) begin
          stb.cntClear = 1'b1;
          phaseNext    = PH_READY;
        end else if (goW && !needMore) begin
          startNext = 1'b1;
          phaseNext = PH_EXEC;
        end else if (wrFifo && needMore) begin
          stb.cntInc = 1'b1;
        end
      end
      PH_EXEC: begin
        if (cancelW) begin
          stb.rcLoadCancel = 1'b1;
          stb.rdRewind     = 1'b1;
          cancelNext       = 1'b1;
          phaseNext        = PH_RESP;
        end else if (engDone) begin
          stb.rcLoadEng = 1'b1;
          stb.rdRewind  = 1'b1;
          phaseNext     = PH_RESP;
        end
      end
      default: begin
        if (cmdReadyW) begin
          stb.cntClear = 1'b1;
          phaseNext    = PH_READY;
        end else if (retryW) begin
          stb.rdRewind = 1'b1;
        end else if (hostRdEn && respLeft) begin
          stb.rdInc = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_READY;
      engStart  <= 1'b0;
      engCancel <= 1'b0;
    end else begin
      phase     <= phaseNext;
      engStart  <= startNext;
      engCancel <= cancelNext;
    end
  end

  always_comb begin
    statusByte             = 8'h00;
    statusByte[BIT_VALID]  = 1'b1;
    statusByte[BIT_READY]  = (phase == PH_READY);
    statusByte[BIT_AVAIL]  = (phase == PH_RESP) && respLeft;
    statusByte[BIT_EXPECT] = (phase == PH_READY) || (phase == PH_RECV && needMore);
    statusByte[BIT_SELF]   = SELF_TEST_DONE;
  end

  AST_START_IN_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> phase == PH_EXEC); // R5
  AST_GO_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RECV && needMore) |=> phase != PH_EXEC); // R5
  AST_EXEC_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == PH_EXEC && phase != PH_EXEC) |->
      $past(engDone || (hostWrEn && hostWrSel == SEL_EXT && hostWrData[0]))); // R9
  AST_CANCEL_TO_RESP: assert property (@(posedge clk) disable iff (!rstN)
    engCancel |-> phase == PH_RESP); // R9
  AST_READY_XOR_AVAIL: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[BIT_READY] && statusByte[BIT_AVAIL])); // R6

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
  import cmdseq_pkg::*;
#(
  parameter int MAX_CMD   = 16,
  parameter int BURST_MAX = 8,
  parameter logic [1:0]  FAMILY    = 2'b01,
  parameter logic [31:0] CANCEL_RC = 32'h0000_0909
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostWrSel,
  input  logic [7:0]  hostWrData,
  input  logic        hostRdEn,
  output logic [7:0]  readData,
  output logic [7:0]  statusByte,
  output logic [7:0]  extStatusByte,
  output logic [15:0] burstCount,
  output logic        engStart,
  output logic        engCancel,
  input  logic        engDone,
  input  logic [31:0] engRc
);
  phase_t  phase;
  strobe_t stb;
  logic    needMore, respLeft;

  assign extStatusByte = {4'b0000, FAMILY, 2'b00};

  cmdseq_ctrl #(.SELF_TEST_DONE(1'b1)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostWrSel(hostWrSel), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .engDone(engDone),
    .needMore(needMore), .respLeft(respLeft),
    .phase(phase), .stb(stb), .statusByte(statusByte),
    .engStart(engStart), .engCancel(engCancel)
  );

  cmdseq_data #(.MAX_CMD(MAX_CMD), .BURST_MAX(BURST_MAX), .CANCEL_RC(CANCEL_RC)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(hostWrData), .phase(phase),
    .engRc(engRc), .needMore(needMore), .respLeft(respLeft),
    .burstCount(burstCount), .readData(readData)
  );

endmodule

// File: tb/test_cmdseq_top.sv
module test_cmdseq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostWrSel = 2'd0;
  logic [7:0]  hostWrData = 8'h00;
  logic        hostRdEn = 1'b0;
  logic [7:0]  readData, statusByte, extStatusByte;
  logic [15:0] burstCount;
  logic        engStart, engCancel;
  logic        engDone = 1'b0;
  logic [31:0] engRc = 32'h0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmdseq_top i_cmdseq_top (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrSel(hostWrSel),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .readData(readData),
    .statusByte(statusByte), .extStatusByte(extStatusByte),
    .burstCount(burstCount), .engStart(engStart), .engCancel(engCancel),
    .engDone(engDone), .engRc(engRc)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [7:0] d);
    hostWrEn = 1'b1; hostWrSel = sel; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrData = 8'h00;
  endtask

  task automatic pop();
    hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic finishEngine(input logic [31:0] rc);
    engDone = 1'b1; engRc = rc;
    @(negedge clk);
    engDone = 1'b0;
  endtask

  task automatic sendCmd(input logic [31:0] lenField, input int nBytes);
    for (int i = 0; i < nBytes; i++) begin
      logic [7:0] b;
      case (i)
        0: b = 8'h80;
        1: b = 8'h01;
        2: b = lenField[31:24];
        3: b = lenField[23:16];
        4: b = lenField[15:8];
        5: b = lenField[7:0];
        default: b = 8'(i);
      endcase
      hostWrite(2'd2, b);
    end
  endtask

  function automatic logic [7:0] frameExp(input int i, input logic [31:0] rc);
    case (i)
      0: return 8'h80;
      1: return 8'h01;
      5: return 8'h0A;
      6: return rc[31:24];
      7: return rc[23:16];
      8: return rc[15:8];
      9: return rc[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic readFrame(input string req, input logic [31:0] rc);
    for (int i = 0; i < 10; i++) begin
      check(req, $sformatf("frame byte %0d", i), readData, frameExp(i, rc));
      pop();
    end
  endtask

  task automatic t_reset();
    check("R1", "status", statusByte, 8'hCC);
    check("R1", "ext status", extStatusByte, 8'h04);
    check("R1", "burst", burstCount, 6);
    check("R1", "readData", readData, 0);
  endtask

  task automatic t_normal();
    hostWrite(2'd2, 8'h80);
    check("R2", "status after first byte", statusByte, 8'h8C);
    check("R4", "burst after first byte", burstCount, 5);
    sendCmd(32'd10, 0);
    hostWrite(2'd2, 8'h01);
    hostWrite(2'd2, 8'h00);
    hostWrite(2'd2, 8'h00);
    hostWrite(2'd2, 8'h00);
    hostWrite(2'd2, 8'h0A);
    check("R4", "burst after header", burstCount, 4);
    hostWrite(2'd0, 8'h20);
    check("R5", "early go ignored status", statusByte, 8'h8C);
    check("R5", "early go no start", engStart, 0);
    for (int i = 0; i < 4; i++) hostWrite(2'd2, 8'h55);
    check("R3", "expect cleared", statusByte, 8'h84);
    check("R4", "burst when full", burstCount, 0);
    hostWrite(2'd2, 8'h66);
    check("R3", "extra byte ignored", statusByte, 8'h84);
    hostWrite(2'd0, 8'h20);
    check("R5", "engStart pulse", engStart, 1);
    check("R5", "exec status", statusByte, 8'h84);
    check("R4", "exec burst", burstCount, 0);
    @(negedge clk);
    check("R5", "engStart one cycle", engStart, 0);
    finishEngine(32'h1234_5678);
    check("R6", "data available", statusByte, 8'h94);
    check("R4", "resp burst", burstCount, 8);
    readFrame("R7", 32'h1234_5678);
    check("R7", "avail cleared", statusByte, 8'h84);
    check("R7", "readData empty", readData, 0);
    pop();
    check("R7", "pop past end", statusByte, 8'h84);
    hostWrite(2'd0, 8'h02);
    check("R8", "retry avail", statusByte, 8'h94);
    check("R8", "retry first byte", readData, 8'h80);
    for (int i = 0; i < 6; i++) pop();
    check("R4", "resp burst left 4", burstCount, 4);
    hostWrite(2'd1, 8'h01);
    check("R10", "cancel in resp byte", readData, 8'h12);
    check("R10", "cancel in resp no pulse", engCancel, 0);
    hostWrite(2'd0, 8'h40);
    check("R11", "cmdReady from resp", statusByte, 8'hCC);
    check("R11", "burst back to 6", burstCount, 6);
  endtask

  task automatic t_cancel();
    sendCmd(32'd10, 10);
    hostWrite(2'd1, 8'h01);
    check("R10", "cancel in recv ignored", statusByte, 8'h84);
    hostWrite(2'd0, 8'h20);
    hostWrite(2'd0, 8'h40);
    check("R11", "cmdReady in exec ignored", statusByte, 8'h84);
    hostWrite(2'd1, 8'h01);
    check("R9", "cancel pulse", engCancel, 1);
    check("R9", "cancel enters resp", statusByte, 8'h94);
    finishEngine(32'hDEAD_BEEF);
    readFrame("R9", 32'h0000_0909);
    hostWrite(2'd0, 8'h40);
    hostWrite(2'd0, 8'h02);
    check("R8", "retry in ready ignored", statusByte, 8'hCC);
    check("R8", "retry in ready burst", burstCount, 6);
  endtask

  task automatic t_length();
    sendCmd(32'd3, 5);
    check("R3", "short length still expects", statusByte, 8'h8C);
    hostWrite(2'd2, 8'h03);
    check("R3", "short length done at 6", statusByte, 8'h84);
    hostWrite(2'd0, 8'h40);
    check("R11", "cmdReady from recv", statusByte, 8'hCC);
    sendCmd(32'd256, 6);
    check("R4", "burst capped", burstCount, 8);
    for (int i = 0; i < 9; i++) hostWrite(2'd2, 8'h11);
    check("R3", "one byte below cap", statusByte, 8'h8C);
    check("R4", "burst one left", burstCount, 1);
    hostWrite(2'd2, 8'h11);
    check("R3", "cap reached", statusByte, 8'h84);
  endtask

  task automatic t_priority();
    hostWrite(2'd0, 8'h60);
    check("R12", "ready beats go", statusByte, 8'hCC);
    check("R12", "no start", engStart, 0);
    sendCmd(32'd6, 6);
    hostWrite(2'd0, 8'h20);
    finishEngine(32'h0000_0001);
    pop();
    hostWrite(2'd0, 8'h42);
    check("R12", "ready beats retry", statusByte, 8'hCC);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_cancel();
    t_length();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule